// File: doc/BRIEF.md
# Multi-User Interprocessor Mailbox

This block is a memory-mapped message exchange point shared by several processors, each called a user. It holds a set of small hardware FIFOs of 32-bit words. A processor posts a message by writing a FIFO's message register. The receiving processor takes the oldest word by reading that same register. Per-FIFO registers report how many words are queued and whether the FIFO is full.

Every user has its own interrupt status and enable state, which cover two events for each FIFO: "holds a message" and "has room". A status bit is cleared by writing 1 to it. Each user drives one level interrupt line, which is high while any enabled status bit of that user is set. A parameter selects one of two register layouts. The split layout gives each user separate enable-set and enable-clear registers. The legacy layout gives each user one read/write enable register, which software updates by read-modify-write.

The bus is a simple single-address port with separate write and read strobes. Read data is registered, so it appears one cycle after the read strobe.

Top module: `ipc_mailbox`

## Requirements
- R1: While reset is held and after it is released, every FIFO reads as empty (word count 0, full flag 0), every user's enable reads 0, every interrupt line is low and the read-data output is 0.
- R2: The register at byte address 0x000 returns the REV_ID parameter and ignores writes.
- R3: For FIFO m, a write to address 0x040+4m appends the word and a read of that address returns and removes the oldest word, in first-in first-out order. Address 0x0C0+4m reads the number of queued words.
- R4: Address 0x080+4m reads 1 while FIFO m holds DEPTH (default 4) words and 0 otherwise. A write to a FIFO that is full in that cycle is dropped, and the stored words are unchanged.
- R5: A read of an empty FIFO's message address returns 0 and leaves the FIFO unchanged.
- R6: In each user's status word, bit 2m (new message, FIFO m) is set in the cycle after FIFO m becomes non-empty and stays set until written with 1. Writing 1 clears it only if the FIFO is empty by then. Writing 0 has no effect. Every user sees every FIFO's events.
- R7: Status bit 2m+1 (room, FIFO m) is set whenever FIFO m is not full. Writing 1 to it clears it only while the FIFO is full, and it sets again in the cycle after a word leaves the FIFO.
- R8: In the split layout (LEGACY=0), user u's status is at 0x104+0x10u. Writing 1s at 0x108+0x10u sets only those enable bits, and writing 1s at 0x10C+0x10u clears only those bits. Both addresses read back the enable word.
- R9: In the legacy layout (LEGACY=1), user u's status is at 0x100+8u and its enable is at 0x104+8u. A write there replaces the whole enable word.
- R10: The interrupt output irq_o[u] is high exactly while some bit is set in both user u's status and user u's enable. Other users' lines are independent of it.
- R11: bus_rdata changes only on the clock edge that samples bus_re high, and it then holds that read's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Byte address, word aligned |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_re | input | 1 | Read strobe (a read of a message address pops) |
| bus_rdata | output | DW | Registered read data |
| irq_o | output | N_USERS | One level interrupt per user |

## Verification
The hardest states to reach are the ones where an acknowledge has no effect. Writing 1 to a new-message bit while words are still queued must leave the bit set. Writing 1 to a room bit clears it only while the FIFO is full. To reach these states, the stimulus fills a FIFO to its full depth, then writes an extra word that must be dropped. It then acknowledges before and after draining, and reads the status after each step. Interrupt routing is checked by enabling different events for the two users and watching both lines as a FIFO fills and drains. A second instance covers the legacy layout's overwrite behaviour.

// File: rtl/ipc_mbx_pkg.sv
// Shared types of the mailbox: decoded register selection and user-side operations.
package ipc_mbx_pkg;

    // Kind of register an address selects.
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_REV,
        SEL_MSG,
        SEL_FULL,
        SEL_LEVEL,
        SEL_ISTAT,
        SEL_IEN,
        SEL_ISET,
        SEL_ICLR
    } sel_kind_e;

    // Decoded selection: register kind plus FIFO or user index.
    typedef struct packed {
        sel_kind_e  kind;
        logic [7:0] idx;
    } sel_t;

    // Write operation applied to one user's interrupt state.
    typedef enum logic [2:0] {
        UOP_NONE,
        UOP_ACK,
        UOP_LOAD,
        UOP_SET,
        UOP_CLR
    } uop_e;

endpackage

// File: rtl/ipc_mbx_decode.sv
// Address decoder: maps a byte address to a register kind and index.
// Assumes N_FIFOS <= 16, N_USERS <= 256 and AW wide enough to cover 0x100 plus the user area.
// LEGACY selects the user-area layout (8-byte stride with one enable, or 16-byte stride with set/clear).
module ipc_mbx_decode
    import ipc_mbx_pkg::*;
#(
    parameter int AW      = 12,
    parameter int N_FIFOS = 4,
    parameter int N_USERS = 2,
    parameter int LEGACY  = 0
) (
    input  logic [AW-1:0] addr,
    output sel_t          sel
);
    localparam logic [AW-1:0] FIFO_LIM  = AW'(N_FIFOS);
    localparam logic [AW-1:0] USER_LIM  = AW'(N_USERS);
    localparam logic [AW-1:0] USER_BASE = AW'('h100);

    logic [AW-1:0] grp;
    logic [AW-1:0] fidx;
    logic [AW-1:0] uoff;
    logic [AW-1:0] uidx;
    logic [3:0]    usub;
    sel_t          usel;

    assign grp  = addr >> 6;
    assign fidx = AW'(addr[5:2]);
    assign uoff = addr - USER_BASE;

    generate
        if (LEGACY != 0) begin : g_legacy
            assign uidx = uoff >> 3;
            assign usub = {1'b0, uoff[2:0]};
            // Legacy user area: status then read/write enable.
            always_comb begin
                usel = '{kind: SEL_NONE, idx: 8'd0};
                if (uidx < USER_LIM) begin
                    usel.idx = 8'(uidx);
                    case (usub)
                        4'h0:    usel.kind = SEL_ISTAT;
                        4'h4:    usel.kind = SEL_IEN;
                        default: usel.kind = SEL_NONE;
                    endcase
                end
            end
        end else begin : g_split
            assign uidx = uoff >> 4;
            assign usub = uoff[3:0];
            // Split user area: status, enable-set, enable-clear.
            always_comb begin
                usel = '{kind: SEL_NONE, idx: 8'd0};
                if (uidx < USER_LIM) begin
                    usel.idx = 8'(uidx);
                    case (usub)
                        4'h4:    usel.kind = SEL_ISTAT;
                        4'h8:    usel.kind = SEL_ISET;
                        4'hC:    usel.kind = SEL_ICLR;
                        default: usel.kind = SEL_NONE;
                    endcase
                end
            end
        end
    endgenerate

    // Top-level decode: revision, FIFO area, user area.
    always_comb begin
        sel = '{kind: SEL_NONE, idx: 8'd0};
        if (addr[1:0] == 2'b00) begin
            if (addr == '0) begin
                sel.kind = SEL_REV;
            end else if (addr < USER_BASE) begin
                if (fidx < FIFO_LIM) begin
                    sel.idx = 8'(fidx);
                    case (grp)
                        AW'(1):  sel.kind = SEL_MSG;
                        AW'(2):  sel.kind = SEL_FULL;
                        AW'(3):  sel.kind = SEL_LEVEL;
                        default: sel.kind = SEL_NONE;
                    endcase
                end
            end else begin
                sel = usel;
            end
        end
    end

endmodule

// File: rtl/ipc_mbx_fifo.sv
// One message FIFO: circular buffer with word count.
// A push while full is dropped, and a pop while empty does nothing.
// The head word is only meaningful while the FIFO is not empty.
module ipc_mbx_fifo #(
    parameter int  DW    = 32,
    parameter int  DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam int            PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LVL_MAX  = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [CW-1:0] lvl;
    logic          do_push;
    logic          do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PW'(1);
    endfunction

    assign full    = (lvl == LVL_MAX);
    assign empty   = (lvl == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];
    assign level   = lvl;

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            lvl  <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            lvl <= lvl + CW'(do_push) - CW'(do_pop);
        end
    end

    // Word storage, written on accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LVL_MAX) else $error("FIFO count above depth");

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> full) else $error("push into full FIFO changed it");

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push |=> empty) else $error("pop of empty FIFO changed it");

endmodule

// File: rtl/ipc_mbx_user.sv
// Interrupt state of one user: sticky status with write-1-to-clear, enable mask, level interrupt.
// ev carries the per-cycle event conditions (non-empty and not-full per FIFO).
// LEGACY picks a whole-word enable load, otherwise bitwise set and clear.
module ipc_mbx_user
    import ipc_mbx_pkg::*;
#(
    parameter int N_EV   = 8,
    parameter int LEGACY = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  uop_e            op,
    input  logic [N_EV-1:0] wdata,
    input  logic [N_EV-1:0] ev,
    output logic [N_EV-1:0] stat,
    output logic [N_EV-1:0] en,
    output logic            irq
);
    logic [N_EV-1:0] ack_mask;

    assign ack_mask = (op == UOP_ACK) ? wdata : '0;

    // Status: a pending event condition wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~ack_mask) | ev;
    end

    generate
        if (LEGACY != 0) begin : g_load
            // Enable replaced as a whole word.
            always_ff @(posedge clk) begin
                if (!rst_n)              en <= '0;
                else if (op == UOP_LOAD) en <= wdata;
            end

            assert_enable_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
                op == UOP_LOAD |=> en == $past(wdata)) else $error("enable load lost");
        end else begin : g_setclr
            // Enable updated bitwise through set and clear operations.
            always_ff @(posedge clk) begin
                if (!rst_n)                  en <= '0;
                else if (op == UOP_SET)      en <= en | wdata;
                else if (op == UOP_CLR)      en <= en & ~wdata;
            end

            assert_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
                op == UOP_SET |=> (en & $past(wdata)) == $past(wdata)) else $error("enable set lost");

            assert_enable_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
                op == UOP_CLR |=> (en & $past(wdata)) == '0) else $error("enable clear lost");
        end
    endgenerate

    assign irq = |(stat & en);

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op != UOP_ACK |=> (stat & $past(stat)) == $past(stat)) else $error("status bit dropped without ack");

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op == UOP_ACK |=> (stat & $past(wdata) & ~$past(ev)) == '0) else $error("ack did not clear idle bit");

endmodule

// File: rtl/ipc_mailbox.sv
// Multi-user mailbox: N_FIFOS message FIFOs, N_USERS interrupt contexts, registered read port.
// Assumes 2*N_FIFOS <= DW and word-aligned bus addresses. A read of a message address pops.
// Bus writes and reads share one address. Read data is valid the cycle after bus_re.
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter int          N_USERS = 2,
    parameter int          N_FIFOS = 4,
    parameter int          DEPTH   = 4,
    parameter int          DW      = 32,
    parameter int          AW      = 12,
    parameter int          LEGACY  = 0,
    parameter logic [31:0] REV_ID  = 32'h0000_0102
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_we,
    input  logic [DW-1:0]      bus_wdata,
    input  logic               bus_re,
    output logic [DW-1:0]      bus_rdata,
    output logic [N_USERS-1:0] irq_o
);
    localparam int N_EV = 2 * N_FIFOS;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int FW   = (N_FIFOS > 1) ? $clog2(N_FIFOS) : 1;
    localparam int UW   = (N_USERS > 1) ? $clog2(N_USERS) : 1;

    sel_t             sel;
    logic [DW-1:0]    head  [N_FIFOS];
    logic [CW-1:0]    lvl   [N_FIFOS];
    logic [N_FIFOS-1:0] full_v;
    logic [N_FIFOS-1:0] empty_v;
    logic [N_EV-1:0]  ev;
    logic [N_EV-1:0]  stat  [N_USERS];
    logic [N_EV-1:0]  en    [N_USERS];
    logic [DW-1:0]    rd_val;
    logic [FW-1:0]    fsel;
    logic [UW-1:0]    usel;

    ipc_mbx_decode #(
        .AW(AW), .N_FIFOS(N_FIFOS), .N_USERS(N_USERS), .LEGACY(LEGACY)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    generate
        for (genvar g = 0; g < N_FIFOS; g++) begin : g_fifo
            logic push_g;
            logic pop_g;
            assign push_g = bus_we && (sel.kind == SEL_MSG) && (sel.idx == 8'(g));
            assign pop_g  = bus_re && (sel.kind == SEL_MSG) && (sel.idx == 8'(g));

            ipc_mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (push_g),
                .push_data(bus_wdata),
                .pop      (pop_g),
                .head     (head[g]),
                .level    (lvl[g]),
                .full     (full_v[g]),
                .empty    (empty_v[g])
            );

            assign ev[2*g]   = !empty_v[g];
            assign ev[2*g+1] = !full_v[g];
        end

        for (genvar u = 0; u < N_USERS; u++) begin : g_user
            uop_e op_u;
            // Select the operation a bus write applies to this user.
            always_comb begin
                op_u = UOP_NONE;
                if (bus_we && (sel.idx == 8'(u))) begin
                    case (sel.kind)
                        SEL_ISTAT: op_u = UOP_ACK;
                        SEL_IEN:   op_u = UOP_LOAD;
                        SEL_ISET:  op_u = UOP_SET;
                        SEL_ICLR:  op_u = UOP_CLR;
                        default:   op_u = UOP_NONE;
                    endcase
                end
            end

            ipc_mbx_user #(.N_EV(N_EV), .LEGACY(LEGACY)) u_user (
                .clk  (clk),
                .rst_n(rst_n),
                .op   (op_u),
                .wdata(bus_wdata[N_EV-1:0]),
                .ev   (ev),
                .stat (stat[u]),
                .en   (en[u]),
                .irq  (irq_o[u])
            );
        end
    endgenerate

    assign fsel = sel.idx[FW-1:0];
    assign usel = sel.idx[UW-1:0];

    // Read multiplexer over all readable registers.
    always_comb begin
        rd_val = '0;
        case (sel.kind)
            SEL_REV:   rd_val = DW'(REV_ID);
            SEL_MSG:   rd_val = empty_v[fsel] ? '0 : head[fsel];
            SEL_FULL:  rd_val = DW'(full_v[fsel]);
            SEL_LEVEL: rd_val = DW'(lvl[fsel]);
            SEL_ISTAT: rd_val = DW'(stat[usel]);
            SEL_IEN,
            SEL_ISET,
            SEL_ICLR:  rd_val = DW'(en[usel]);
            default:   rd_val = '0;
        endcase
    end

    // Registered read data, updated only by a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_val;
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata)) else $error("read data moved without a read");

endmodule

// File: tb/sim_ipc_mailbox.sv
// Directed bench: u0 uses the split layout, u1 the legacy layout.
module sim_ipc_mailbox;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] REV        = 32'h0000_0A31;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] a_addr = '0, b_addr = '0;
    logic        a_we = 1'b0, b_we = 1'b0, a_re = 1'b0, b_re = 1'b0;
    logic [31:0] a_wd = '0, b_wd = '0;
    logic [31:0] a_rd, b_rd;
    logic [1:0]  a_irq, b_irq;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipc_mailbox #(.LEGACY(0), .REV_ID(REV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_we(a_we), .bus_wdata(a_wd),
        .bus_re(a_re), .bus_rdata(a_rd), .irq_o(a_irq));

    ipc_mailbox #(.LEGACY(1), .REV_ID(REV)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we), .bus_wdata(b_wd),
        .bus_re(b_re), .bus_rdata(b_rd), .irq_o(b_irq));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit leg, logic [11:0] ad, logic [31:0] d);
        if (leg) begin b_addr = ad; b_wd = d; b_we = 1'b1; end
        else     begin a_addr = ad; a_wd = d; a_we = 1'b1; end
        @(negedge clk);
        a_we = 1'b0;
        b_we = 1'b0;
    endtask

    task automatic rd(bit leg, logic [11:0] ad, output logic [31:0] d);
        if (leg) begin b_addr = ad; b_re = 1'b1; end
        else     begin a_addr = ad; a_re = 1'b1; end
        @(negedge clk);
        a_re = 1'b0;
        b_re = 1'b0;
        d = leg ? b_rd : a_rd;
    endtask

    task automatic expect_rd(string req, bit leg, logic [11:0] ad, logic [31:0] exp);
        logic [31:0] v;
        rd(leg, ad, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;  // R1
        repeat (3) @(negedge clk);
        check("R1 irq during reset", {30'd0, a_irq}, 32'd0);
        check("R1 legacy irq during reset", {30'd0, b_irq}, 32'd0);
        check("R1 rdata during reset", a_rd, 32'd0);
        rst_n = 1'b1;
        idle(2);
        for (int m = 0; m < 4; m++) begin
            expect_rd("R1 level", 1'b0, 12'(12'h0C0 + 4 * m), 32'd0);
            expect_rd("R1 full", 1'b0, 12'(12'h080 + 4 * m), 32'd0);
        end
        expect_rd("R1 enable user0", 1'b0, 12'h108, 32'd0);
        expect_rd("R1 enable user1", 1'b0, 12'h118, 32'd0);
        expect_rd("R1 legacy enable user0", 1'b1, 12'h104, 32'd0);
        expect_rd("R1 legacy enable user1", 1'b1, 12'h10C, 32'd0);
        check("R1 irq after reset", {30'd0, a_irq}, 32'd0);
    endtask

    task automatic t_rev;  // R2
        expect_rd("R2 revision", 1'b0, 12'h000, REV);
        wr(1'b0, 12'h000, 32'hFFFF_FFFF);
        expect_rd("R2 revision after write", 1'b0, 12'h000, REV);
    endtask

    task automatic t_order;  // R3
        wr(1'b0, 12'h044, 32'h1111_1111);
        wr(1'b0, 12'h044, 32'h2222_2222);
        wr(1'b0, 12'h044, 32'h3333_3333);
        expect_rd("R3 level three", 1'b0, 12'h0C4, 32'd3);
        expect_rd("R3 first out", 1'b0, 12'h044, 32'h1111_1111);
        expect_rd("R3 second out", 1'b0, 12'h044, 32'h2222_2222);
        expect_rd("R3 third out", 1'b0, 12'h044, 32'h3333_3333);
        expect_rd("R3 level drained", 1'b0, 12'h0C4, 32'd0);
    endtask

    task automatic t_full;  // R4
        for (int i = 0; i < 5; i++) wr(1'b0, 12'h048, 32'hA000_0000 + 32'(i));
        expect_rd("R4 full flag", 1'b0, 12'h088, 32'd1);
        expect_rd("R4 level at depth", 1'b0, 12'h0C8, 32'd4);
        expect_rd("R4 pop 0", 1'b0, 12'h048, 32'hA000_0000);
        expect_rd("R4 full flag after pop", 1'b0, 12'h088, 32'd0);
        for (int i = 1; i < 4; i++) expect_rd("R4 pop rest", 1'b0, 12'h048, 32'hA000_0000 + 32'(i));
        expect_rd("R4 fifth word dropped", 1'b0, 12'h0C8, 32'd0);
    endtask

    task automatic t_empty;  // R5
        expect_rd("R5 empty read", 1'b0, 12'h04C, 32'd0);
        expect_rd("R5 level unchanged", 1'b0, 12'h0CC, 32'd0);
        wr(1'b0, 12'h04C, 32'h0000_0055);
        expect_rd("R5 word after empty read", 1'b0, 12'h04C, 32'h0000_0055);
        expect_rd("R5 level back to zero", 1'b0, 12'h0CC, 32'd0);
    endtask

    task automatic t_newmsg;  // R6
        wr(1'b0, 12'h104, 32'hFF);
        wr(1'b0, 12'h114, 32'hFF);
        idle(1);
        expect_rd("R6 cleared status", 1'b0, 12'h104, 32'hAA);
        wr(1'b0, 12'h040, 32'h0000_C0DE);
        idle(2);
        expect_rd("R6 new message user0", 1'b0, 12'h104, 32'hAB);
        expect_rd("R6 new message user1", 1'b0, 12'h114, 32'hAB);
        wr(1'b0, 12'h104, 32'h01);
        idle(1);
        expect_rd("R6 ack while non-empty", 1'b0, 12'h104, 32'hAB);
        wr(1'b0, 12'h104, 32'h00);
        idle(1);
        expect_rd("R6 write zero", 1'b0, 12'h104, 32'hAB);
        expect_rd("R6 pop", 1'b0, 12'h040, 32'h0000_C0DE);
        idle(1);
        expect_rd("R6 sticky after drain", 1'b0, 12'h104, 32'hAB);
        wr(1'b0, 12'h104, 32'h01);
        idle(1);
        expect_rd("R6 ack when empty", 1'b0, 12'h104, 32'hAA);
        expect_rd("R6 other user untouched", 1'b0, 12'h114, 32'hAB);
        wr(1'b0, 12'h114, 32'hFF);
    endtask

    task automatic t_notfull;  // R7
        wr(1'b0, 12'h104, 32'hFF);
        for (int i = 0; i < 4; i++) wr(1'b0, 12'h04C, 32'hD000_0000 + 32'(i));
        idle(2);
        expect_rd("R7 full, room bit still set", 1'b0, 12'h104, 32'hEA);
        wr(1'b0, 12'h104, 32'h80);
        idle(1);
        expect_rd("R7 room cleared while full", 1'b0, 12'h104, 32'h6A);
        expect_rd("R7 pop", 1'b0, 12'h04C, 32'hD000_0000);
        idle(2);
        expect_rd("R7 room re-set", 1'b0, 12'h104, 32'hEA);
        for (int i = 1; i < 4; i++) expect_rd("R7 drain", 1'b0, 12'h04C, 32'hD000_0000 + 32'(i));
        wr(1'b0, 12'h104, 32'hC0);
        idle(1);
        expect_rd("R7 room ack while not full", 1'b0, 12'h104, 32'hAA);
    endtask

    task automatic t_enable;  // R8
        wr(1'b0, 12'h108, 32'h05);
        expect_rd("R8 set", 1'b0, 12'h108, 32'h05);
        wr(1'b0, 12'h108, 32'h10);
        expect_rd("R8 set keeps others", 1'b0, 12'h108, 32'h15);
        wr(1'b0, 12'h10C, 32'h04);
        expect_rd("R8 clear via clear address", 1'b0, 12'h10C, 32'h11);
        expect_rd("R8 clear via set address", 1'b0, 12'h108, 32'h11);
        expect_rd("R8 user1 untouched", 1'b0, 12'h118, 32'h00);
        wr(1'b0, 12'h10C, 32'hFF);
        expect_rd("R8 clear all", 1'b0, 12'h108, 32'h00);
    endtask

    task automatic t_irq;  // R10
        logic [31:0] v;
        wr(1'b0, 12'h114, 32'hFF);
        wr(1'b0, 12'h104, 32'hFF);
        wr(1'b0, 12'h108, 32'h01);
        idle(2);
        check("R10 no event", {30'd0, a_irq}, 32'd0);
        wr(1'b0, 12'h040, 32'h77);
        idle(2);
        check("R10 user0 fires", {30'd0, a_irq}, 32'd1);
        wr(1'b0, 12'h118, 32'h08);
        idle(1);
        check("R10 user1 room event", {30'd0, a_irq}, 32'd3);
        wr(1'b0, 12'h104, 32'h01);
        idle(1);
        check("R10 ack while queued", {30'd0, a_irq}, 32'd3);
        rd(1'b0, 12'h040, v);
        wr(1'b0, 12'h104, 32'h01);
        idle(1);
        check("R10 user0 quiet", {30'd0, a_irq}, 32'd2);
        wr(1'b0, 12'h11C, 32'hFF);
        idle(1);
        check("R10 both quiet", {30'd0, a_irq}, 32'd0);
        wr(1'b0, 12'h10C, 32'hFF);
    endtask

    task automatic t_legacy;  // R9
        expect_rd("R9 legacy status user0", 1'b1, 12'h100, 32'hAA);
        expect_rd("R9 legacy status user1", 1'b1, 12'h108, 32'hAA);
        wr(1'b1, 12'h104, 32'h0A);
        expect_rd("R9 legacy enable load", 1'b1, 12'h104, 32'h0A);
        wr(1'b1, 12'h104, 32'h02);
        expect_rd("R9 legacy enable overwrite", 1'b1, 12'h104, 32'h02);
        expect_rd("R9 legacy user1 enable", 1'b1, 12'h10C, 32'h00);
        check("R9 legacy irq user0", {30'd0, b_irq}, 32'd1);
        wr(1'b1, 12'h10C, 32'h80);
        check("R9 legacy irq both", {30'd0, b_irq}, 32'd3);
        wr(1'b1, 12'h104, 32'h00);
        wr(1'b1, 12'h10C, 32'h00);
        check("R9 legacy irq off", {30'd0, b_irq}, 32'd0);
        wr(1'b1, 12'h040, 32'h1234);
        idle(2);
        expect_rd("R9 legacy new message", 1'b1, 12'h100, 32'hAB);
        expect_rd("R9 legacy pop", 1'b1, 12'h040, 32'h1234);
        wr(1'b1, 12'h100, 32'h01);
        idle(1);
        expect_rd("R9 legacy ack", 1'b1, 12'h100, 32'hAA);
    endtask

    task automatic t_rdlat;  // R11
        wr(1'b0, 12'h040, 32'h1111_AAAA);
        wr(1'b0, 12'h040, 32'h2222_BBBB);
        expect_rd("R11 read value", 1'b0, 12'h040, 32'h1111_AAAA);
        idle(3);
        check("R11 rdata held", a_rd, 32'h1111_AAAA);
        expect_rd("R11 single pop", 1'b0, 12'h0C0, 32'd1);
        expect_rd("R11 next word", 1'b0, 12'h040, 32'h2222_BBBB);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_rev();
        t_order();
        t_full();
        t_empty();
        t_newmsg();
        t_notfull();
        t_enable();
        t_irq();
        t_legacy();
        t_rdlat();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule